// File: doc/BRIEF.md
# Auto-Reload Up-Counter with Byte-Lane Access

This block is a 16-bit timer that counts up by one on every clock cycle where its count-enable input is high. It has a 16-bit reload register that software can only write. The CPU reaches both registers through an 8-bit data bus at a single pair of byte addresses. A write to the pair goes to the reload register, and that write also loads the counter at once. A read from the pair returns the live counter.

The bus moves 8 bits at a time, but each transfer carries a 16-bit value. An 8-bit holding latch joins the two byte accesses into one indivisible transfer, and software must access the upper byte first.
- For a write, the upper byte waits in the latch. The lower-byte write then commits the whole word.
- For a read, the upper-byte read captures the low byte of the counter into the latch. The lower-byte read then returns that captured byte, so the two halves belong to the same count.

When the counter overflows, it either reloads from the reload register or wraps to zero, depending on a mode input. An overflow also sets a sticky flag, which software clears.

Top module: `reload_timer16`

## Requirements
- R1: After reset, the counter, the reload register and the overflow flag are all zero, so a 16-bit read returns 0x0000.
- R2: A write with `bus_addr`=0 (upper byte) stores the byte in the holding latch only. The counter and the reload register keep their values.
- R3: A write with `bus_addr`=1 (lower byte) loads {latch, bus byte} into both the reload register and the counter on the same clock edge.
- R4: The counter rises by exactly one on each edge where `cnt_en` is high, and holds otherwise.
- R5: With `auto_reload`=1, a counted edge at 0xFFFF loads the counter from the reload register. The overflow period is therefore 65536 minus the reload value, which gives 1 cycle for a reload value of 0xFFFF.
- R6: With `auto_reload`=0, a counted edge at 0xFFFF wraps the counter to 0x0000.
- R7: Every overflow sets `ovf_flag`, and the flag stays set until an edge with `ovf_clr` high clears it. An overflow on the same edge as a clear wins, and the flag stays 1.
- R8: While `bus_sel` and `bus_rd` are high, `bus_addr`=0 returns the counter's high byte and latches its low byte on that edge. `bus_addr`=1 returns the latched byte. `bus_rdata` is 0 when no read is active.
- R9: A lower-byte write on the same edge as a count tick or an overflow takes priority. The counter takes the written value, and the flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Count-enable tick |
| auto_reload | input | 1 | 1 = reload on overflow, 0 = wrap to zero |
| bus_sel | input | 1 | Register pair selected |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 1 | Byte lane: 0 upper, 1 lower |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte |
| ovf_clr | input | 1 | Clear the overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench writes a lone upper byte and then forces an overflow from 0xFFFE. A design that committed on the upper-byte write would reload a corrupted value. It reads the upper byte, lets the counter run across a carry into the high byte, and then reads the lower byte. A design without the read latch would return the newer low byte. It sets a period of one cycle with reload 0xFFFF, and it raises a clear and an overflow on the same edge to check that set wins. It also lands a lower-byte write on a tick at 0xFFFF. A design that let counting win would show 0x0000 or a raised flag instead of the written word.

// File: rtl/rtimer_pkg.sv
package rtimer_pkg;
  parameter int DATA_W = 8;
  localparam int CNT_W = 2 * DATA_W;

  typedef enum logic {
    LANE_HI = 1'b0,
    LANE_LO = 1'b1
  } lane_e;

  // next counter value for a counted edge
  function automatic logic [CNT_W-1:0] step_up(input logic [CNT_W-1:0] c);
    return c + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  // true when a counted edge carries out of the top
  function automatic logic at_top(input logic [CNT_W-1:0] c);
    return &c;
  endfunction
endpackage

// File: rtl/tmp_bridge.sv
module tmp_bridge
  import rtimer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic              rd,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] rdata,
  output logic              hi_wr,
  output logic              commit,
  output logic [CNT_W-1:0]  commit_val
);
  logic [DATA_W-1:0] tmp_q;
  logic              hi_rd;

  assign hi_wr      = sel && wr && (lane_e'(addr) == LANE_HI);
  assign commit     = sel && wr && (lane_e'(addr) == LANE_LO);
  assign hi_rd      = sel && rd && !wr && (lane_e'(addr) == LANE_HI);
  assign commit_val = {tmp_q, wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tmp_q <= '0;
    else if (hi_wr) tmp_q <= wdata;
    else if (hi_rd) tmp_q <= cnt[DATA_W-1:0];
  end

  always_comb begin
    rdata = '0;
    if (sel && rd) begin
      if (lane_e'(addr) == LANE_HI) rdata = cnt[CNT_W-1:DATA_W];
      else                          rdata = tmp_q;
    end
  end
endmodule

// File: rtl/count_core.sv
module count_core
  import rtimer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             auto_rl,
  input  logic             commit,
  input  logic [CNT_W-1:0] commit_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] reload_q,
  output logic             ovf_evt
);
  assign ovf_evt = tick && !commit && at_top(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reload_q <= '0;
    else if (commit) reload_q <= commit_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (commit)  cnt_q <= commit_val;
    else if (ovf_evt) cnt_q <= auto_rl ? reload_q : '0;
    else if (tick)    cnt_q <= step_up(cnt_q);
  end
endmodule

// File: rtl/ovf_sticky.sv
module ovf_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/reload_timer16.sv
module reload_timer16
  import rtimer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              auto_reload,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ovf_clr,
  output logic              ovf_flag
);
  logic             hi_wr;
  logic             commit;
  logic [CNT_W-1:0] commit_val;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload_q;
  logic             ovf_evt;

  tmp_bridge u_bridge (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .rd(bus_rd),
    .addr(bus_addr), .wdata(bus_wdata), .cnt(cnt_q), .rdata(bus_rdata),
    .hi_wr(hi_wr), .commit(commit), .commit_val(commit_val)
  );

  count_core u_core (
    .clk(clk), .rst_n(rst_n), .tick(cnt_en), .auto_rl(auto_reload),
    .commit(commit), .commit_val(commit_val), .cnt_q(cnt_q),
    .reload_q(reload_q), .ovf_evt(ovf_evt)
  );

  ovf_sticky u_flag (
    .clk(clk), .rst_n(rst_n), .set(ovf_evt), .clr(ovf_clr), .flag(ovf_flag)
  );
endmodule

// File: rtl/rtimer_chk.sv
module rtimer_chk
  import rtimer_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic             auto_reload,
  input logic             ovf_clr,
  input logic             hi_wr,
  input logic             commit,
  input logic             ovf_evt,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] reload_q,
  input logic             ovf_flag
);
  // R2
  hi_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_wr && !cnt_en) |=> ($stable(cnt_q) && $stable(reload_q)));
  // R3
  commit_loads_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (cnt_q == reload_q));
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !commit) |=> $stable(cnt_q));
  // R4
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !commit && !ovf_evt) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R5
  auto_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && auto_reload) |=> (cnt_q == reload_q));
  // R6
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !auto_reload) |=> (cnt_q == '0));
  // R7
  flag_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag);
  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
  // R9
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !ovf_evt);
endmodule

bind reload_timer16 rtimer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .auto_reload(auto_reload),
  .ovf_clr(ovf_clr), .hi_wr(hi_wr), .commit(commit), .ovf_evt(ovf_evt),
  .cnt_q(cnt_q), .reload_q(reload_q), .ovf_flag(ovf_flag)
);

// File: tb/reload_timer16_tb.sv
module reload_timer16_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b0;
  logic       auto_reload = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       ovf_clr = 1'b0;
  logic       ovf_flag;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  reload_timer16 u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .auto_reload(auto_reload),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovf_clr(ovf_clr),
    .ovf_flag(ovf_flag)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic lane, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = lane; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr16(input logic [15:0] v);
    wr_byte(1'b0, v[15:8]);
    wr_byte(1'b1, v[7:0]);
  endtask

  task automatic rd16(output logic [15:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = 1'b0;
    #1 v[15:8] = bus_rdata;
    @(negedge clk);
    bus_addr = 1'b1;
    #1 v[7:0] = bus_rdata;
    bus_sel = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic run(input int n);
    @(negedge clk);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd16(v);
    check("R1 counter", v, 16'h0000);
    check("R1 flag", {15'd0, ovf_flag}, 16'h0000);
    @(negedge clk);
    check("R8 idle rdata", {8'd0, bus_rdata}, 16'h0000);
  endtask

  task automatic t_write_and_count();
    logic [15:0] v;
    wr16(16'hAA55);
    rd16(v);
    check("R3 commit", v, 16'hAA55);
    run(10);
    rd16(v);
    check("R4 count 10", v, 16'hAA5F);
    wr_byte(1'b0, 16'h00);
    rd16(v);
    check("R2 counter kept", v, 16'hAA5F);
  endtask

  task automatic t_hi_only_reload();
    logic [15:0] v;
    auto_reload = 1'b1;
    wr16(16'hFFFE);
    wr_byte(1'b0, 8'h12);
    run(2);
    rd16(v);
    check("R2 reload kept", v, 16'hFFFE);
    check("R7 flag set", {15'd0, ovf_flag}, 16'h0001);
    clear_flag();
    check("R7 cleared", {15'd0, ovf_flag}, 16'h0000);
  endtask

  task automatic t_autoreload_period();
    logic [15:0] v;
    auto_reload = 1'b1;
    wr16(16'hFFFD);
    run(2);
    check("R5 no ovf early", {15'd0, ovf_flag}, 16'h0000);
    run(1);
    rd16(v);
    check("R5 reloaded", v, 16'hFFFD);
    check("R5 flag", {15'd0, ovf_flag}, 16'h0001);
    clear_flag();
    wr16(16'hFFFF);
    run(5);
    rd16(v);
    check("R5 period 1", v, 16'hFFFF);
    @(negedge clk);
    cnt_en = 1'b1; ovf_clr = 1'b1;
    @(negedge clk);
    cnt_en = 1'b0; ovf_clr = 1'b0;
    check("R7 set wins", {15'd0, ovf_flag}, 16'h0001);
    clear_flag();
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    auto_reload = 1'b0;
    wr16(16'hFFFE);
    run(3);
    rd16(v);
    check("R6 wrap", v, 16'h0001);
    check("R7 flag wrap", {15'd0, ovf_flag}, 16'h0001);
    clear_flag();
  endtask

  task automatic t_coherent_read();
    logic [15:0] v;
    wr16(16'h12F0);
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = 1'b0;
    #1 check("R8 high byte", {8'd0, bus_rdata}, 16'h0012);
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
    run(20);
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = 1'b1;
    #1 check("R8 latched low", {8'd0, bus_rdata}, 16'h00F0);
    bus_sel = 1'b0; bus_rd = 1'b0;
    rd16(v);
    check("R8 new value", v, 16'h1304);
  endtask

  task automatic t_write_priority();
    logic [15:0] v;
    auto_reload = 1'b0;
    wr16(16'hFFFF);
    wr_byte(1'b0, 8'h34);
    @(negedge clk);
    cnt_en = 1'b1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 8'h56;
    @(negedge clk);
    cnt_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    rd16(v);
    check("R9 written wins", v, 16'h3456);
    check("R9 no flag", {15'd0, ovf_flag}, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_and_count();
    t_hi_only_reload();
    t_autoreload_period();
    t_wrap();
    t_coherent_read();
    t_write_priority();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule